// File: doc/BRIEF.md
# Key-Locked Watchdog Timer with Index/Data Register Access

This block is a watchdog timer whose control registers sit behind a two-port configuration window. One port selects an index and the other carries data. Software can reach the registers only after it writes a two-byte unlock key to the index port and then selects the watchdog page. A single close key shuts the window again. The window protects the timer from stray writes by code that does not own it.

Once the window is open, software picks whether the timer counts seconds or minutes and loads an 8-bit timeout. It can let keyboard or mouse activity pulses restart the count, and it sets the enable bit. The timer runs only when the software enable bit and the board-level permit input are both high. It counts down on the selected tick pulse. When it reaches zero it raises `wdt_reset`, which stays high until the count is reloaded or the timer is turned off.

The access path is a three-state machine:
- `ACC_LOCKED` goes to `ACC_HALF` on an index write of 0x87.
- `ACC_HALF` goes to `ACC_OPEN` on a second index write of 0x87, and falls back to `ACC_LOCKED` on any other write.
- `ACC_OPEN` returns to `ACC_LOCKED` on an index write of 0xAA.

Idle cycles never move the machine.

Top module: `keylock_wdt`

## Requirements
- R1: The window opens only after two index-port writes of 0x87 with no other bus write between them. Any other write in between, to either port, returns the machine to `ACC_LOCKED`. Cycles with no write do not break the sequence.
- R2: While open, an index write of 0x07 followed by a data write of 0x08 selects the watchdog page. Registers are reachable only with page 0x08 selected. The page selection is cleared whenever the window closes.
- R3: An index write of 0xAA while open closes the window. The data port is unreachable from the next cycle on.
- R4: Without access (not open, or page not 0x08), data-port writes change nothing and data-port reads return 0xFF. Index-port reads and reads of an unlisted index also return 0xFF.
- R5: The register layout, visible from the cycle after the write, is:
  - index 0x30, bit 0: enable.
  - index 0xF5, bit 3: count unit, 0 = seconds, 1 = minutes.
  - index 0xF7, bit 6: keyboard reload enable.
  - index 0xF7, bit 7: mouse reload enable.
  - All other bits of these registers read as 0.
- R6: The timer is active only when the enable bit and `hw_permit` are both 1. While it is inactive, the count holds and `wdt_reset` is 0.
- R7: While active, each pulse of the selected tick (`tick_sec` in seconds mode, `tick_min` in minutes mode) decrements the count by one, down to a floor of 0. The other tick has no effect.
- R8: `wdt_reset` is 1 exactly while the timer is active and the count is 0. It follows `hw_permit` and the enable bit in the same cycle, and it stays high until a reload or a disable.
- R9: A data write to index 0xF6 loads both the count and the stored timeout. Reading index 0xF6 returns the live count.
- R10: While active, a `kbd_evt` pulse with the keyboard bit set, or a `mouse_evt` pulse with the mouse bit set, reloads the count from the stored timeout. A pulse whose bit is clear has no effect. In the same cycle, a register load takes priority over an event reload, and an event reload takes priority over a decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe |
| bus_sel_data | input | 1 | Port select: 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational; 0xFF when not readable |
| tick_sec | input | 1 | One-second tick pulse |
| tick_min | input | 1 | One-minute tick pulse |
| kbd_evt | input | 1 | Keyboard activity pulse |
| mouse_evt | input | 1 | Mouse activity pulse |
| hw_permit | input | 1 | Board strap that must be 1 for the timer to run |
| wdt_reset | output | 1 | Watchdog expiry reset request |

## Verification
Register writes, key writes, tick pulses and activity pulses all take effect at the clock edge that samples them. Their results are visible one cycle later. `bus_rdata` and `wdt_reset` are combinational from registered state. In addition, `bus_rdata` follows `bus_rd` within the same cycle, and `wdt_reset` follows `hw_permit` within the same cycle. The bench drives every input on the falling edge and holds it for one full cycle. It checks registered results on the next falling edge, and it checks combinational outputs 1 ns after the input change.

// File: rtl/keylock_wdt_pkg.sv
package keylock_wdt_pkg;
    localparam int BUS_W = 8;

    typedef enum logic [1:0] {
        ACC_LOCKED = 2'd0,
        ACC_HALF   = 2'd1,
        ACC_OPEN   = 2'd2
    } acc_state_t;

    localparam logic [BUS_W-1:0] KEY_OPEN  = 8'h87;
    localparam logic [BUS_W-1:0] KEY_CLOSE = 8'hAA;
    localparam logic [BUS_W-1:0] IDX_PAGE  = 8'h07;
    localparam logic [BUS_W-1:0] PAGE_WDT  = 8'h08;
    localparam logic [BUS_W-1:0] REG_EN    = 8'h30;
    localparam logic [BUS_W-1:0] REG_UNIT  = 8'hF5;
    localparam logic [BUS_W-1:0] REG_COUNT = 8'hF6;
    localparam logic [BUS_W-1:0] REG_EVT   = 8'hF7;
endpackage

// File: rtl/keylock_access.sv
module keylock_access
    import keylock_wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             sel_data,
    input  logic [BUS_W-1:0] wdata,
    output acc_state_t       state,
    output logic [BUS_W-1:0] index_q,
    output logic             granted
);
    acc_state_t       state_q, state_d;
    logic [BUS_W-1:0] page_q;
    logic             idx_wr, dat_wr;

    assign idx_wr = wr && !sel_data;
    assign dat_wr = wr && sel_data;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_LOCKED: if (idx_wr && wdata == KEY_OPEN) state_d = ACC_HALF;
            ACC_HALF: begin
                if (idx_wr && wdata == KEY_OPEN) state_d = ACC_OPEN;
                else if (wr)                     state_d = ACC_LOCKED;
            end
            ACC_OPEN:   if (idx_wr && wdata == KEY_CLOSE) state_d = ACC_LOCKED;
            default:    state_d = ACC_LOCKED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_LOCKED;
        else        state_q <= state_d;
    end

    // output registers: index and page, cleared whenever not open
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            index_q <= '0;
            page_q  <= '0;
        end else if (state_q != ACC_OPEN) begin
            index_q <= '0;
            page_q  <= '0;
        end else begin
            if (idx_wr && wdata != KEY_CLOSE) index_q <= wdata;
            if (dat_wr && index_q == IDX_PAGE) page_q <= wdata;
        end
    end

    assign state   = state_q;
    assign granted = (state_q == ACC_OPEN) && (page_q == PAGE_WDT);
endmodule

// File: rtl/keylock_regs.sv
module keylock_regs
    import keylock_wdt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ok,
    input  logic             rd_ok,
    input  logic [BUS_W-1:0] index,
    input  logic [BUS_W-1:0] wdata,
    input  logic [CNT_W-1:0] count,
    output logic             en,
    output logic             unit_min,
    output logic             kbd_en,
    output logic             mouse_en,
    output logic             load,
    output logic [BUS_W-1:0] rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en       <= 1'b0;
            unit_min <= 1'b0;
            kbd_en   <= 1'b0;
            mouse_en <= 1'b0;
        end else if (wr_ok) begin
            if (index == REG_EN)   en       <= wdata[0];
            if (index == REG_UNIT) unit_min <= wdata[3];
            if (index == REG_EVT) begin
                kbd_en   <= wdata[6];
                mouse_en <= wdata[7];
            end
        end
    end

    assign load = wr_ok && (index == REG_COUNT);

    always_comb begin
        rdata = 8'hFF;
        if (rd_ok) begin
            case (index)
                REG_EN:    rdata = {7'b0, en};
                REG_UNIT:  rdata = {4'b0, unit_min, 3'b0};
                REG_COUNT: rdata = BUS_W'(count);
                REG_EVT:   rdata = {mouse_en, kbd_en, 6'b0};
                default:   rdata = 8'hFF;
            endcase
        end
    end
endmodule

// File: rtl/keylock_timer.sv
module keylock_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             active,
    input  logic             unit_min,
    input  logic             tick_sec,
    input  logic             tick_min,
    input  logic             kbd_evt,
    input  logic             mouse_evt,
    input  logic             kbd_en,
    input  logic             mouse_en,
    output logic [CNT_W-1:0] count,
    output logic             tick_sel,
    output logic             evt_reload,
    output logic             expired
);
    logic [CNT_W-1:0] timeout_q, count_q;

    assign tick_sel   = unit_min ? tick_min : tick_sec;
    assign evt_reload = active && ((kbd_evt && kbd_en) || (mouse_evt && mouse_en));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timeout_q <= '0;
            count_q   <= '0;
        end else if (load) begin
            timeout_q <= load_val;
            count_q   <= load_val;
        end else if (evt_reload) begin
            count_q <= timeout_q;
        end else if (active && tick_sel && count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign count   = count_q;
    assign expired = active && (count_q == '0);
endmodule

// File: rtl/keylock_wdt.sv
module keylock_wdt
    import keylock_wdt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic             bus_sel_data,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             tick_sec,
    input  logic             tick_min,
    input  logic             kbd_evt,
    input  logic             mouse_evt,
    input  logic             hw_permit,
    output logic             wdt_reset
);
    acc_state_t       acc_state;
    logic [BUS_W-1:0] index_q;
    logic             granted, wr_ok, rd_ok;
    logic             en, unit_min, kbd_en, mouse_en, load, active;
    logic             tick_sel, evt_reload;
    logic [CNT_W-1:0] count;

    keylock_access u_access (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel_data(bus_sel_data),
        .wdata(bus_wdata), .state(acc_state), .index_q(index_q), .granted(granted)
    );

    assign wr_ok  = bus_wr && bus_sel_data && granted;
    assign rd_ok  = bus_rd && bus_sel_data && granted;
    assign active = en && hw_permit;

    keylock_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .rd_ok(rd_ok), .index(index_q),
        .wdata(bus_wdata), .count(count), .en(en), .unit_min(unit_min),
        .kbd_en(kbd_en), .mouse_en(mouse_en), .load(load), .rdata(bus_rdata)
    );

    keylock_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(CNT_W'(bus_wdata)),
        .active(active), .unit_min(unit_min), .tick_sec(tick_sec), .tick_min(tick_min),
        .kbd_evt(kbd_evt), .mouse_evt(mouse_evt), .kbd_en(kbd_en), .mouse_en(mouse_en),
        .count(count), .tick_sel(tick_sel), .evt_reload(evt_reload), .expired(wdt_reset)
    );
endmodule

// File: rtl/keylock_wdt_chk.sv
module keylock_wdt_chk
    import keylock_wdt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_sel_data,
    input logic [BUS_W-1:0] bus_wdata,
    input acc_state_t       acc_state,
    input logic             granted,
    input logic [CNT_W-1:0] count,
    input logic             active,
    input logic             tick_sel,
    input logic             load,
    input logic             evt_reload,
    input logic             hw_permit,
    input logic             wdt_reset
);
    logic key_wr;
    assign key_wr = bus_wr && !bus_sel_data && bus_wdata == KEY_OPEN;

    AST_KEY_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_state == ACC_LOCKED && key_wr) |=> acc_state == ACC_HALF); // R1
    AST_KEY_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_state == ACC_HALF && bus_wr && !key_wr) |=> acc_state == ACC_LOCKED); // R1
    AST_NO_GRANT_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_state != ACC_OPEN) |-> !granted); // R2
    AST_CLOSE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_state == ACC_OPEN && bus_wr && !bus_sel_data && bus_wdata == KEY_CLOSE)
        |=> (acc_state == ACC_LOCKED && !granted)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !load) |=> $stable(count)); // R6
    AST_NO_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_permit |-> !wdt_reset); // R6
    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tick_sel && !load && !evt_reload && count != '0)
        |=> count == $past(count) - 1'b1); // R7
    AST_FIRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_reset && !load && !evt_reload) |=> (wdt_reset || !active)); // R8
endmodule

bind keylock_wdt keylock_wdt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel_data(bus_sel_data),
    .bus_wdata(bus_wdata), .acc_state(acc_state), .granted(granted), .count(count),
    .active(active), .tick_sel(tick_sel), .load(load), .evt_reload(evt_reload),
    .hw_permit(hw_permit), .wdt_reset(wdt_reset)
);

// File: tb/test_keylock_wdt.sv
module test_keylock_wdt;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_sel_data = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tick_sec = 1'b0, tick_min = 1'b0, kbd_evt = 1'b0, mouse_evt = 1'b0;
    logic       hw_permit = 1'b0;
    logic       wdt_reset;
    int         n_tests = 0, n_fail = 0;

    keylock_wdt i_keylock_wdt (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_sel_data(bus_sel_data), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_sec(tick_sec), .tick_min(tick_min), .kbd_evt(kbd_evt),
        .mouse_evt(mouse_evt), .hw_permit(hw_permit), .wdt_reset(wdt_reset)
    );

    always #10ns clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic sel, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_sel_data = sel; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0; bus_sel_data = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic write_reg(input logic [7:0] idx, input logic [7:0] val);
        bus_write(1'b0, idx);
        bus_write(1'b1, val);
    endtask

    task automatic read_reg(input logic [7:0] idx, output logic [7:0] v);
        bus_write(1'b0, idx);
        @(negedge clk); bus_rd = 1'b1; bus_sel_data = 1'b1;
        #1ns v = bus_rdata;
        @(negedge clk); bus_rd = 1'b0; bus_sel_data = 1'b0;
    endtask

    // 0 = tick_sec, 1 = tick_min, 2 = kbd_evt, 3 = mouse_evt
    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: tick_sec = 1'b1;
            1: tick_min = 1'b1;
            2: kbd_evt = 1'b1;
            default: mouse_evt = 1'b1;
        endcase
        @(negedge clk);
        tick_sec = 1'b0; tick_min = 1'b0; kbd_evt = 1'b0; mouse_evt = 1'b0;
    endtask

    task automatic open_session();
        bus_write(1'b0, 8'h87);
        bus_write(1'b0, 8'h87);
        write_reg(8'h07, 8'h08);
    endtask

    task automatic test_reset_and_locked();
        logic [7:0] v;
        check("R8 reset output low", {7'b0, wdt_reset}, 8'h00);
        @(negedge clk); bus_rd = 1'b1; bus_sel_data = 1'b1;
        #1ns check("R4 locked read", bus_rdata, 8'hFF);
        @(negedge clk); bus_rd = 1'b0; bus_sel_data = 1'b0;
        hw_permit = 1'b1;
        write_reg(8'h30, 8'h01);
        check("R4 locked enable write ignored", {7'b0, wdt_reset}, 8'h00);
        open_session();
        read_reg(8'h30, v);
        check("R4 enable still clear", v, 8'h00);
        bus_write(1'b0, 8'hAA);
    endtask

    task automatic test_key_sequence();
        logic [7:0] v;
        bus_write(1'b0, 8'h87); bus_write(1'b0, 8'h11); bus_write(1'b0, 8'h87);
        write_reg(8'h07, 8'h08);
        read_reg(8'hF6, v);
        check("R1 broken by other index", v, 8'hFF);
        bus_write(1'b0, 8'h87); bus_write(1'b1, 8'h55); bus_write(1'b0, 8'h87);
        write_reg(8'h07, 8'h08);
        read_reg(8'hF6, v);
        check("R1 broken by data write", v, 8'hFF);
        open_session();
        read_reg(8'hF6, v);
        check("R1 clean unlock", v, 8'h00);
        bus_write(1'b0, 8'hAA);
    endtask

    task automatic test_page_and_lock();
        logic [7:0] v;
        bus_write(1'b0, 8'h87); bus_write(1'b0, 8'h87);
        read_reg(8'hF6, v);
        check("R2 no page", v, 8'hFF);
        write_reg(8'h07, 8'h09);
        read_reg(8'hF6, v);
        check("R2 wrong page", v, 8'hFF);
        write_reg(8'h07, 8'h08);
        read_reg(8'hF6, v);
        check("R2 page 08", v, 8'h00);
        bus_write(1'b0, 8'hAA);
        read_reg(8'hF6, v);
        check("R3 closed after AA", v, 8'hFF);
        bus_write(1'b0, 8'h87); bus_write(1'b0, 8'h87);
        read_reg(8'hF6, v);
        check("R2 page cleared on close", v, 8'hFF);
        write_reg(8'h07, 8'h08);
        read_reg(8'h99, v);
        check("R4 unlisted index", v, 8'hFF);
    endtask

    task automatic test_register_layout();
        logic [7:0] v;
        write_reg(8'hF5, 8'hFF); read_reg(8'hF5, v); check("R5 unit bit", v, 8'h08);
        write_reg(8'hF7, 8'hFF); read_reg(8'hF7, v); check("R5 event bits", v, 8'hC0);
        write_reg(8'hF6, 8'h5A); read_reg(8'hF6, v); check("R9 count load", v, 8'h5A);
        write_reg(8'h30, 8'hFE); read_reg(8'h30, v); check("R5 enable bit", v, 8'h00);
        write_reg(8'hF5, 8'h00);
        write_reg(8'hF7, 8'h00);
    endtask

    task automatic test_countdown_seconds();
        logic [7:0] v;
        write_reg(8'hF6, 8'h03);
        write_reg(8'h30, 8'h01);
        check("R8 no fire at 3", {7'b0, wdt_reset}, 8'h00);
        pulse(1);
        read_reg(8'hF6, v); check("R7 minute tick ignored", v, 8'h03);
        pulse(0); pulse(0);
        read_reg(8'hF6, v); check("R7 two seconds", v, 8'h01);
        check("R8 no fire at 1", {7'b0, wdt_reset}, 8'h00);
        pulse(0);
        check("R8 fire at zero", {7'b0, wdt_reset}, 8'h01);
        pulse(0);
        read_reg(8'hF6, v); check("R7 floor at zero", v, 8'h00);
        check("R8 fire held", {7'b0, wdt_reset}, 8'h01);
        write_reg(8'hF6, 8'h02);
        check("R9 reload clears fire", {7'b0, wdt_reset}, 8'h00);
    endtask

    task automatic test_minutes();
        logic [7:0] v;
        write_reg(8'hF5, 8'h08);
        pulse(0);
        read_reg(8'hF6, v); check("R7 second tick ignored", v, 8'h02);
        pulse(1);
        read_reg(8'hF6, v); check("R7 minute tick", v, 8'h01);
    endtask

    task automatic test_permit();
        logic [7:0] v;
        @(negedge clk); hw_permit = 1'b0;
        pulse(1); pulse(1);
        read_reg(8'hF6, v); check("R6 hold without permit", v, 8'h01);
        write_reg(8'hF6, 8'h00);
        check("R6 no fire without permit", {7'b0, wdt_reset}, 8'h00);
        @(negedge clk); hw_permit = 1'b1;
        #1ns check("R6 fire when permitted", {7'b0, wdt_reset}, 8'h01);
        write_reg(8'h30, 8'h00);
        check("R8 disable releases", {7'b0, wdt_reset}, 8'h00);
    endtask

    task automatic test_events();
        logic [7:0] v;
        write_reg(8'hF5, 8'h00);
        write_reg(8'hF6, 8'h04);
        write_reg(8'hF7, 8'h40);
        write_reg(8'h30, 8'h01);
        pulse(0); pulse(0);
        read_reg(8'hF6, v); check("R7 count before event", v, 8'h02);
        pulse(2);
        read_reg(8'hF6, v); check("R10 keyboard reload", v, 8'h04);
        pulse(0);
        pulse(3);
        read_reg(8'hF6, v); check("R10 mouse masked", v, 8'h03);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset_and_locked();
        test_key_sequence();
        test_page_and_lock();
        test_register_layout();
        test_countdown_seconds();
        test_minutes();
        test_permit();
        test_events();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule